// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This block makes the stall and forwarding decisions for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. It holds the control part of the decode, execute, memory and writeback pipeline registers: a valid bit, the destination register, the write enable, a load flag and, for decode, the two source register numbers. From these it drives the hold signals for fetch and decode, the bubble into execute, the operand forwarding selects for execute, and the flush taken when a branch resolves.

The pipeline it controls has a single bypass path, from the execute result back to the execute operand inputs. The register file returns a value only in the cycle after the one in which writeback writes it. Branches resolve in execute. So any dependence that cannot use the bypass holds the consumer in decode until its producer has left writeback. A load followed directly by a use of its result is held for three cycles.

Top module: `hz_interlock`

## Requirements
- R1: While `rst_ni` is low, every valid bit, stall, bubble, flush and forward output is 0.
- R2: Independent instructions presented on consecutive cycles each reach writeback exactly four cycles after being presented, with no stall.
- R3: A consumer whose source matches the destination of a non-load producer directly in execute does not stall. In its execute cycle the select for that operand is 1 (execute result) and the other select is 0 (register file).
- R4: A consumer directly behind a load that writes one of its sources is held in decode for three stall cycles. It enters execute four cycles after entering decode.
- R5: A consumer whose producer is in memory holds in decode while the producer is in memory and in writeback. It proceeds in the cycle after the producer leaves writeback.
- R6: During a stall, `stall_fetch_o`, `stall_decode_o` and `bubble_ex_o` are all 1. The decode contents and the fetched instruction are kept, and execute receives an invalid entry each stalled cycle.
- R7: A source of register 0, and any producer with write enable 0, causes neither a stall nor a forward.
- R8: When `ex_taken_i` is 1 and execute holds a valid instruction, `flush_o` is 1. In the next cycle decode and execute are invalid, and the instruction fetched in the flush cycle is discarded. `ex_taken_i` has no effect when execute is empty.
- R9: A flush overrides any pending interlock: in the flush cycle the stall signals are 0.
- R10: When both execute and memory hold producers of the same register, the younger one in execute decides. A forwardable match there forwards without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| if_valid_i | input | 1 | Fetched instruction is valid |
| if_rs1_i | input | REG_W | First source register of fetched instruction |
| if_rs2_i | input | REG_W | Second source register of fetched instruction |
| if_rd_i | input | REG_W | Destination register of fetched instruction |
| if_we_i | input | 1 | Fetched instruction writes its destination |
| if_load_i | input | 1 | Fetched instruction is a load |
| ex_taken_i | input | 1 | Instruction in execute is a taken branch |
| stall_fetch_o | output | 1 | Fetch holds its instruction |
| stall_decode_o | output | 1 | Decode holds its instruction |
| bubble_ex_o | output | 1 | Invalid entry inserted into execute |
| flush_o | output | 1 | Fetch and decode contents are discarded |
| fwd_a_o | output | 1 | First execute operand: 1 execute result, 0 register file |
| fwd_b_o | output | 1 | Second execute operand: 1 execute result, 0 register file |
| id_valid_o | output | 1 | Decode stage valid |
| ex_valid_o | output | 1 | Execute stage valid |
| mem_valid_o | output | 1 | Memory stage valid |
| wb_valid_o | output | 1 | Writeback stage valid |
| wb_we_o | output | 1 | Writeback writes the register file |
| wb_rd_o | output | REG_W | Writeback destination register |

## Verification
The hardest case to reach is a flush that arrives while decode is held by an interlock. A stall pushes a bubble into execute, so a taken branch can only sit in execute beside a stalled consumer when that consumer depends on an instruction older than the branch. The stimulus issues a producer, then a branch, then a consumer of the producer, and asserts the taken input in the cycle the branch reaches execute. The bench checks that the stall signals stay low and that both wrong-path instructions vanish from the writeback stream.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned SRC_N = 2;

  typedef enum logic {
    FWD_RF = 1'b0,
    FWD_EX = 1'b1
  } fwd_sel_e;
endpackage

// File: rtl/hz_pipe_reg.sv
module hz_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         kill_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (kill_i) q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/hz_src_check.sv
module hz_src_check
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             ex_valid_i,
  input  logic             ex_we_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             mem_valid_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             wb_valid_i,
  input  logic             wb_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  output logic             stall_o,
  output fwd_sel_e         fwd_o
);
  logic src_live, hit_ex, hit_mem, hit_wb;

  // register 0 never carries a dependence
  assign src_live = (src_i != '0);
  assign hit_ex   = src_live && ex_valid_i  && ex_we_i  && (ex_rd_i  == src_i);
  assign hit_mem  = src_live && mem_valid_i && mem_we_i && (mem_rd_i == src_i);
  assign hit_wb   = src_live && wb_valid_i  && wb_we_i  && (wb_rd_i  == src_i);

  // youngest producer decides; only a non-load in execute can bypass
  always_comb begin
    fwd_o   = FWD_RF;
    stall_o = 1'b0;
    if (hit_ex) begin
      if (ex_load_i) stall_o = 1'b1;
      else           fwd_o   = FWD_EX;
    end else if (hit_mem || hit_wb) begin
      stall_o = 1'b1;
    end
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             if_valid_i,
  input  logic [REG_W-1:0] if_rs1_i,
  input  logic [REG_W-1:0] if_rs2_i,
  input  logic [REG_W-1:0] if_rd_i,
  input  logic             if_we_i,
  input  logic             if_load_i,
  input  logic             ex_taken_i,
  output logic             stall_fetch_o,
  output logic             stall_decode_o,
  output logic             bubble_ex_o,
  output logic             flush_o,
  output logic             fwd_a_o,
  output logic             fwd_b_o,
  output logic             id_valid_o,
  output logic             ex_valid_o,
  output logic             mem_valid_o,
  output logic             wb_valid_o,
  output logic             wb_we_o,
  output logic [REG_W-1:0] wb_rd_o
);
  // common layout: {rd, load, we, valid}
  localparam int unsigned P_W   = REG_W + 3;
  localparam int unsigned ID_W  = P_W + SRC_N * REG_W;
  localparam int unsigned EX_W  = P_W + SRC_N;
  localparam int unsigned O_V   = 0;
  localparam int unsigned O_WE  = 1;
  localparam int unsigned O_LD  = 2;
  localparam int unsigned O_RD  = 3;
  localparam int unsigned O_SRC = P_W;

  logic [ID_W-1:0] id_d, id_q;
  logic [EX_W-1:0] ex_d, ex_q;
  logic [P_W-1:0]  mem_q, wb_q;

  logic [REG_W-1:0] id_src [SRC_N];
  logic [SRC_N-1:0] src_stall;
  fwd_sel_e         src_fwd [SRC_N];
  logic [SRC_N-1:0] fwd_bits;

  logic hazard, flush, stall;

  // ---------------- decode stage ----------------
  assign id_d = {if_rs2_i, if_rs1_i, if_rd_i, if_load_i, if_we_i & if_valid_i, if_valid_i};

  hz_pipe_reg #(.W(ID_W)) u_id_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (~stall),
    .kill_i (flush),
    .d_i    (id_d),
    .q_o    (id_q)
  );

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    assign id_src[s] = id_q[O_SRC + s*REG_W +: REG_W];

    hz_src_check #(.REG_W(REG_W)) u_chk (
      .src_i       (id_src[s]),
      .ex_valid_i  (ex_q[O_V]),
      .ex_we_i     (ex_q[O_WE]),
      .ex_load_i   (ex_q[O_LD]),
      .ex_rd_i     (ex_q[O_RD +: REG_W]),
      .mem_valid_i (mem_q[O_V]),
      .mem_we_i    (mem_q[O_WE]),
      .mem_rd_i    (mem_q[O_RD +: REG_W]),
      .wb_valid_i  (wb_q[O_V]),
      .wb_we_i     (wb_q[O_WE]),
      .wb_rd_i     (wb_q[O_RD +: REG_W]),
      .stall_o     (src_stall[s]),
      .fwd_o       (src_fwd[s])
    );

    assign fwd_bits[s] = id_q[O_V] && (src_fwd[s] == FWD_EX);
  end

  // ---------------- control ----------------
  assign flush  = ex_q[O_V] && ex_taken_i;
  assign hazard = id_q[O_V] && (|src_stall);
  assign stall  = hazard && !flush;

  // ---------------- execute stage ----------------
  assign ex_d = {fwd_bits, id_q[P_W-1:0]};

  hz_pipe_reg #(.W(EX_W)) u_ex_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (1'b1),
    .kill_i (flush | hazard),
    .d_i    (ex_d),
    .q_o    (ex_q)
  );

  // ---------------- memory and writeback ----------------
  hz_pipe_reg #(.W(P_W)) u_mem_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (1'b1),
    .kill_i (1'b0),
    .d_i    (ex_q[P_W-1:0]),
    .q_o    (mem_q)
  );

  hz_pipe_reg #(.W(P_W)) u_wb_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (1'b1),
    .kill_i (1'b0),
    .d_i    (mem_q),
    .q_o    (wb_q)
  );

  // ---------------- outputs ----------------
  assign stall_fetch_o  = stall;
  assign stall_decode_o = stall;
  assign bubble_ex_o    = stall;
  assign flush_o        = flush;
  assign fwd_a_o        = ex_q[P_W];
  assign fwd_b_o        = ex_q[P_W+1];
  assign id_valid_o     = id_q[O_V];
  assign ex_valid_o     = ex_q[O_V];
  assign mem_valid_o    = mem_q[O_V];
  assign wb_valid_o     = wb_q[O_V];
  assign wb_we_o        = wb_q[O_WE];
  assign wb_rd_o        = wb_q[O_RD +: REG_W];
endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ex_taken_i,
  input logic stall_decode_o,
  input logic flush_o,
  input logic fwd_a_o,
  input logic fwd_b_o,
  input logic id_valid_o,
  input logic ex_valid_o,
  input logic mem_valid_o,
  input logic wb_valid_o
);
  logic [2:0] stall_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             stall_run <= '0;
    else if (!stall_decode_o)                stall_run <= '0;
    else if (stall_run != 3'd7)              stall_run <= stall_run + 3'd1;
  end

  a_r4_stall_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_run <= 3'd3);

  a_r6_bubble_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_decode_o |=> !ex_valid_o);

  a_r6_decode_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_decode_o |=> id_valid_o);

  a_r8_flush_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (!id_valid_o && !ex_valid_o));

  a_r8_empty_no_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_valid_o |-> !flush_o);

  a_r9_flush_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_taken_i && ex_valid_o) |-> (flush_o && !stall_decode_o));

  a_r3_fwd_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o || fwd_b_o) |-> (ex_valid_o && mem_valid_o));

  a_r2_ex_to_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_valid_o |=> mem_valid_o);

  a_r2_mem_to_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |=> wb_valid_o);
endmodule

bind hz_interlock hz_interlock_chk u_hz_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ex_taken_i     (ex_taken_i),
  .stall_decode_o (stall_decode_o),
  .flush_o        (flush_o),
  .fwd_a_o        (fwd_a_o),
  .fwd_b_o        (fwd_b_o),
  .id_valid_o     (id_valid_o),
  .ex_valid_o     (ex_valid_o),
  .mem_valid_o    (mem_valid_o),
  .wb_valid_o     (wb_valid_o)
);

// File: tb/hz_interlock_tb_top.sv
module hz_interlock_tb_top;
  localparam int RW    = 5;
  localparam int RUN_N = 14;

  typedef struct packed {
    logic [RW-1:0] rs1;
    logic [RW-1:0] rs2;
    logic [RW-1:0] rd;
    logic          we;
    logic          ld;
  } ins_t;

  typedef struct packed {
    logic [RW-1:0] rd;
    int            at;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic if_valid_i = 1'b0;
  logic [RW-1:0] if_rs1_i = '0, if_rs2_i = '0, if_rd_i = '0;
  logic if_we_i = 1'b0, if_load_i = 1'b0, ex_taken_i = 1'b0;
  logic stall_fetch_o, stall_decode_o, bubble_ex_o, flush_o, fwd_a_o, fwd_b_o;
  logic id_valid_o, ex_valid_o, mem_valid_o, wb_valid_o, wb_we_o;
  logic [RW-1:0] wb_rd_o;

  hz_interlock dut_i (.*);

  always #4 clk_i = ~clk_i;

  int   tests = 0, fails = 0, cyc = 0;
  bit   run_on = 0;
  exp_t exp_q[$];
  logic st_log [RUN_N], fl_log [RUN_N], bu_log [RUN_N], fa_log [RUN_N], fb_log [RUN_N];
  logic idv_log [RUN_N], exv_log [RUN_N];

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic ins_t mk(input int rs1, input int rs2, input int rd,
                              input bit we, input bit ld);
    mk.rs1 = RW'(rs1); mk.rs2 = RW'(rs2); mk.rd = RW'(rd); mk.we = we; mk.ld = ld;
  endfunction

  task automatic push_exp(input int rd, input int at);
    exp_t e;
    e.rd = RW'(rd); e.at = at;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor: every retirement must match the next expected item
  always @(negedge clk_i) begin
    if (run_on && wb_valid_o) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected retirement rd", int'(wb_rd_o), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R2 retire rd", int'(wb_rd_o), int'(e.rd));
        check("R2 retire cycle", cyc, e.at);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; if_valid_i = 1'b0; ex_taken_i = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk_i);
    check("R1 reset outputs",
          int'({stall_fetch_o, stall_decode_o, bubble_ex_o, flush_o, fwd_a_o, fwd_b_o,
                id_valid_o, ex_valid_o, mem_valid_o, wb_valid_o}), 0);
    rst_ni = 1'b1;
    cyc = 0;
  endtask

  // driver: fetch model holding its instruction while stalled
  task automatic run_prog(input ins_t prog[$], input int taken_at);
    int k = 0;
    logic sf;
    run_on = 1;
    for (int i = 0; i < RUN_N; i++) begin
      if (k < prog.size()) begin
        if_valid_i = 1'b1;
        if_rs1_i = prog[k].rs1; if_rs2_i = prog[k].rs2; if_rd_i = prog[k].rd;
        if_we_i = prog[k].we; if_load_i = prog[k].ld;
      end else begin
        if_valid_i = 1'b0; if_we_i = 1'b0; if_load_i = 1'b0;
      end
      ex_taken_i = (cyc == taken_at);
      #1;
      st_log[cyc] = stall_decode_o; fl_log[cyc] = flush_o; bu_log[cyc] = bubble_ex_o;
      fa_log[cyc] = fwd_a_o; fb_log[cyc] = fwd_b_o;
      idv_log[cyc] = id_valid_o; exv_log[cyc] = ex_valid_o;
      if (stall_decode_o !== stall_fetch_o || stall_decode_o !== bubble_ex_o)
        check("R6 stall signals agree", int'({stall_fetch_o, bubble_ex_o}),
              stall_decode_o ? 3 : 0);
      sf = stall_fetch_o;
      @(posedge clk_i);
      cyc++;
      if (!sf && k < prog.size()) k++;
      @(negedge clk_i);
    end
    run_on = 0;
    ex_taken_i = 1'b0;
    check("R2 all expected retirements seen", exp_q.size(), 0);
  endtask

  function automatic int stall_total();
    int n = 0;
    for (int c = 0; c < RUN_N; c++) n += int'(st_log[c]);
    return n;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    ins_t p[$];

    // R2 independent stream; R8 taken with empty execute does nothing
    do_reset();
    p = {mk(30,31,1,1,0), mk(30,31,2,1,0), mk(30,31,3,1,0), mk(30,31,4,1,0)};
    push_exp(1,4); push_exp(2,5); push_exp(3,6); push_exp(4,7);
    run_prog(p, 0);
    check("R2 no stall cycles", stall_total(), 0);
    check("R8 taken ignored when execute empty", int'(fl_log[0]), 0);

    // R3 forward from execute
    do_reset();
    p = {mk(30,31,5,1,0), mk(5,30,6,1,0)};
    push_exp(5,4); push_exp(6,5);
    run_prog(p, -1);
    check("R3 no stall", stall_total(), 0);
    check("R3 fwd_a selects execute", int'(fa_log[3]), 1);
    check("R3 fwd_b stays register file", int'(fb_log[3]), 0);

    // R4 / R6 load-use
    do_reset();
    p = {mk(30,31,7,1,1), mk(30,7,8,1,0), mk(30,31,9,1,0)};
    push_exp(7,4); push_exp(8,8); push_exp(9,9);
    run_prog(p, -1);
    check("R4 three stall cycles", stall_total(), 3);
    check("R4 stall starts in decode", int'(st_log[2]), 1);
    check("R4 released after writeback", int'(st_log[5]), 0);
    check("R6 bubbles in execute", int'({exv_log[3], exv_log[4], exv_log[5]}), 0);
    check("R6 bubble flag during stall", int'({bu_log[2], bu_log[3], bu_log[4]}), 7);
    check("R4 consumer enters execute", int'(exv_log[6]), 1);
    check("R4 no forward after load", int'(fb_log[6]), 0);

    // R5 producer in memory
    do_reset();
    p = {mk(30,31,10,1,0), mk(30,31,11,1,0), mk(10,30,12,1,0), mk(30,31,13,1,0)};
    push_exp(10,4); push_exp(11,5); push_exp(12,8); push_exp(13,9);
    run_prog(p, -1);
    check("R5 two stall cycles", stall_total(), 2);
    check("R5 stall while in memory and writeback", int'({st_log[3], st_log[4]}), 3);
    check("R5 no forward from memory", int'(fa_log[6]), 0);

    // R7 register 0 and write-disabled producers
    do_reset();
    p = {mk(30,31,0,1,1), mk(0,0,14,1,0), mk(30,31,15,0,0), mk(15,30,16,1,0)};
    push_exp(0,4); push_exp(14,5); push_exp(15,6); push_exp(16,7);
    run_prog(p, -1);
    check("R7 no stall", stall_total(), 0);
    check("R7 no forward for register 0", int'({fa_log[3], fb_log[3]}), 0);
    check("R7 no forward for write-disabled", int'(fa_log[5]), 0);

    // R8 / R9 flush while decode is interlocked
    do_reset();
    p = {mk(30,31,17,1,0), mk(30,31,18,0,0), mk(17,30,19,1,0),
         mk(30,31,21,1,0), mk(17,30,22,1,0)};
    push_exp(17,4); push_exp(18,5); push_exp(22,8);
    run_prog(p, 3);
    check("R8 flush raised", int'(fl_log[3]), 1);
    check("R9 stall suppressed by flush", int'(st_log[3]), 0);
    check("R8 decode and execute cleared", int'({idv_log[4], exv_log[4]}), 0);
    check("R8 target proceeds without stall", stall_total(), 0);

    // R10 youngest producer decides
    do_reset();
    p = {mk(30,31,23,1,0), mk(30,31,23,1,0), mk(30,23,24,1,0)};
    push_exp(23,4); push_exp(23,5); push_exp(24,6);
    run_prog(p, -1);
    check("R10 no stall", stall_total(), 0);
    check("R10 fwd_b selects execute", int'(fb_log[4]), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule